// File: doc/BRIEF.md
# Three-Alarm Counter Event Unit

This block keeps a 32-bit time count that advances by one on every tick pulse. Three alarm comparators watch it. Each comparator has a 32-bit match value, an enable bit and a sticky event flag. An alarm fires for one cycle when it is enabled, a tick arrives, and the value the counter is about to take equals that alarm's match value. Alarm 0 can also restart the count from zero when it fires. A single interrupt-style output is high while any event flag is set.

Software reaches the block through a flat byte-wide register port made of address, write data, write strobe and combinational read data. One configuration byte holds the enables, the auto-reset switch and the three flags. A flag can only be cleared, by writing 0 to its bit. The match values are loaded one byte at a time. The running count can be read back one byte at a time.

Top module: `alarm_event_unit`

## Requirements
- R1: The configuration byte sits at address 0x07. Its bit 7 always reads 0, and writing 1 to it changes nothing.
- R2: Configuration bits 6, 5 and 4 are the event flags of alarms 2, 1 and 0. A flag becomes 1 in the cycle after its alarm fires.
- R3: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves the flag as it was.
- R4: Bit 3 enables auto-reset. While it is 1, a firing of alarm 0 makes the counter load 0 instead of incrementing, and the alarm 0 event and flag still occur.
- R5: Bits 2, 1 and 0 enable alarms 2, 1 and 0. A disabled alarm never pulses `event_o` and never sets its flag.
- R6: `event_o[i]` is high in a cycle exactly when alarm i is enabled, `tick_i` is high, and the count plus one equals match value i. The event appears in the same cycle as the tick.
- R7: The counter is 32 bits wide, resets to 0, increments by one on each tick and holds otherwise. Its bytes read back, least significant first, at addresses 0x00 to 0x03. Writes to those addresses are ignored.
- R8: `alarm_irq_o` is the OR of the three event flags.
- R9: If an alarm fires in the same cycle that software writes 0 to its flag, the flag ends up set.
- R10: After reset, the configuration byte, the counter and all match values are 0.
- R11: The bytes of match value i are written and read at addresses 0x10 + 4*i + k, where byte k holds bits 8k+7 down to 8k. An address that maps to no register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-advance pulse |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| event_o | output | 3 | One-cycle alarm event pulses, bit i for alarm i |
| alarm_irq_o | output | 1 | High while any event flag is set |
| count_o | output | 32 | Current counter value |

## Verification
The assertions check the following on every cycle:
- the reserved bit reads zero;
- a disabled alarm or a cycle without a tick never produces an event;
- every event leaves its flag set;
- a flag only drops after a write of zero to it;
- an auto-reset firing leaves the counter at zero;
- the counter holds without a tick;
- the interrupt output follows the flags.

Some behaviours only the bench scenarios can show. These are the exact match arithmetic, the byte placement of the match and count registers, and the precedence of a hardware set over a same-cycle clear. The bench compares these against its own model, using directed corners and random writes of match values near the live count.

// File: rtl/aeu_pkg.sv
package aeu_pkg;

    localparam int N_ALARM = 3;

    // Configuration byte layout (bit 7 is reserved and not stored)
    typedef struct packed {
        logic [N_ALARM-1:0] flag;    // bits 6:4
        logic               autorst; // bit 3
        logic [N_ALARM-1:0] en;      // bits 2:0
    } cfg_t;

endpackage

// File: rtl/aeu_counter.sv
module aeu_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic [CNT_W-1:0] count_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;

    assign cnt_next_o = state_q.cnt + CNT_W'(1);

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            state_d.cnt = clear_i ? '0 : cnt_next_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o = state_q.cnt;

endmodule

// File: rtl/aeu_comparator.sv
module aeu_comparator #(
    parameter int CNT_W = 32
) (
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] match_i,
    output logic             hit_o
);

    always_comb begin
        hit_o = en_i && tick_i && (cnt_next_i == match_i);
    end

endmodule

// File: rtl/aeu_regfile.sv
module aeu_regfile
    import aeu_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int REG_AW     = 8,
    parameter int CFG_ADDR   = 'h07,
    parameter int CNT_BASE   = 'h00,
    parameter int MATCH_BASE = 'h10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [REG_AW-1:0]               reg_addr_i,
    input  logic [7:0]                      reg_wdata_i,
    input  logic                            reg_we_i,
    input  logic [N_ALARM-1:0]              event_i,
    input  logic [CNT_W-1:0]                count_i,
    output logic [7:0]                      reg_rdata_o,
    output cfg_t                            cfg_o,
    output logic [N_ALARM-1:0][CNT_W-1:0]   match_o
);

    localparam int BYTES = CNT_W / 8;

    typedef struct packed {
        cfg_t                          cfg;
        logic [N_ALARM-1:0][CNT_W-1:0] match;
    } reg_state_t;

    reg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (reg_we_i) begin
            if (reg_addr_i == REG_AW'(CFG_ADDR)) begin
                state_d.cfg.en      = reg_wdata_i[N_ALARM-1:0];
                state_d.cfg.autorst = reg_wdata_i[3];
                // a written 1 keeps the flag, a written 0 clears it
                state_d.cfg.flag    = state_q.cfg.flag & reg_wdata_i[6:4];
            end
            for (int i = 0; i < N_ALARM; i++) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (reg_addr_i == REG_AW'(MATCH_BASE + i*BYTES + b)) begin
                        state_d.match[i][8*b +: 8] = reg_wdata_i;
                    end
                end
            end
        end
        // hardware set takes precedence over a same-cycle clear
        state_d.cfg.flag = state_d.cfg.flag | event_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == REG_AW'(CFG_ADDR)) begin
            reg_rdata_o = {1'b0, state_q.cfg};
        end
        for (int b = 0; b < BYTES; b++) begin
            if (reg_addr_i == REG_AW'(CNT_BASE + b)) begin
                reg_rdata_o = count_i[8*b +: 8];
            end
        end
        for (int i = 0; i < N_ALARM; i++) begin
            for (int b = 0; b < BYTES; b++) begin
                if (reg_addr_i == REG_AW'(MATCH_BASE + i*BYTES + b)) begin
                    reg_rdata_o = state_q.match[i][8*b +: 8];
                end
            end
        end
    end

    assign cfg_o   = state_q.cfg;
    assign match_o = state_q.match;

endmodule

// File: rtl/alarm_event_unit.sv
module alarm_event_unit
    import aeu_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int REG_AW     = 8,
    parameter int CFG_ADDR   = 'h07,
    parameter int CNT_BASE   = 'h00,
    parameter int MATCH_BASE = 'h10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [REG_AW-1:0]   reg_addr_i,
    input  logic [7:0]          reg_wdata_i,
    input  logic                reg_we_i,
    output logic [7:0]          reg_rdata_o,
    output logic [N_ALARM-1:0]  event_o,
    output logic                alarm_irq_o,
    output logic [CNT_W-1:0]    count_o
);

    cfg_t                          cfg_w;
    logic [N_ALARM-1:0][CNT_W-1:0] match_w;
    logic [CNT_W-1:0]              cnt_next_w;
    logic [N_ALARM-1:0]            hit_w;
    logic                          clear_w;
    logic [N_ALARM-1:0]            flag_w;
    logic [N_ALARM-1:0]            en_w;
    logic                          autorst_w;

    aeu_regfile #(
        .CNT_W      (CNT_W),
        .REG_AW     (REG_AW),
        .CFG_ADDR   (CFG_ADDR),
        .CNT_BASE   (CNT_BASE),
        .MATCH_BASE (MATCH_BASE)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_we_i    (reg_we_i),
        .event_i     (hit_w),
        .count_i     (count_o),
        .reg_rdata_o (reg_rdata_o),
        .cfg_o       (cfg_w),
        .match_o     (match_w)
    );

    generate
        for (genvar g = 0; g < N_ALARM; g++) begin : g_cmp
            aeu_comparator #(.CNT_W(CNT_W)) i_cmp (
                .en_i       (cfg_w.en[g]),
                .tick_i     (tick_i),
                .cnt_next_i (cnt_next_w),
                .match_i    (match_w[g]),
                .hit_o      (hit_w[g])
            );
        end
    endgenerate

    assign clear_w = cfg_w.autorst && hit_w[0];

    aeu_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .clear_i    (clear_w),
        .cnt_next_o (cnt_next_w),
        .count_o    (count_o)
    );

    assign flag_w      = cfg_w.flag;
    assign en_w        = cfg_w.en;
    assign autorst_w   = cfg_w.autorst;
    assign event_o     = hit_w;
    assign alarm_irq_o = |flag_w;

endmodule

// File: rtl/aeu_checker.sv
module aeu_checker #(
    parameter int CNT_W    = 32,
    parameter int REG_AW   = 8,
    parameter int CFG_ADDR = 'h07
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic [REG_AW-1:0] reg_addr_i,
    input logic [7:0]        reg_wdata_i,
    input logic              reg_we_i,
    input logic [7:0]        reg_rdata_o,
    input logic [2:0]        event_o,
    input logic              alarm_irq_o,
    input logic [CNT_W-1:0]  count_o,
    input logic [2:0]        flag_w,
    input logic [2:0]        en_w,
    input logic              autorst_w
);

    logic       cfg_wr;
    logic [2:0] kept;

    assign cfg_wr = reg_we_i && (reg_addr_i == REG_AW'(CFG_ADDR));
    assign kept   = cfg_wr ? (flag_w & reg_wdata_i[6:4]) : flag_w;

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i == REG_AW'(CFG_ADDR)) |-> (reg_rdata_o[7] == 1'b0)); // R1

    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o != 3'b000) |=> ((flag_w & $past(event_o)) == $past(event_o))); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (kept != 3'b000) |=> (($past(kept) & ~flag_w) == 3'b000)); // R3

    AST_AUTORST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (event_o[0] && autorst_w) |=> (count_o == '0)); // R4

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_o & ~en_w) == 3'b000)); // R5

    AST_EVENT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> (event_o == 3'b000)); // R6

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_o)); // R7

    AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq_o == (flag_w != 3'b000)); // R8

endmodule

bind alarm_event_unit aeu_checker #(
    .CNT_W    (CNT_W),
    .REG_AW   (REG_AW),
    .CFG_ADDR (CFG_ADDR)
) i_aeu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_we_i    (reg_we_i),
    .reg_rdata_o (reg_rdata_o),
    .event_o     (event_o),
    .alarm_irq_o (alarm_irq_o),
    .count_o     (count_o),
    .flag_w      (flag_w),
    .en_w        (en_w),
    .autorst_w   (autorst_w)
);

// File: tb/test_alarm_event_unit.sv
`timescale 1ns/1ps
module test_alarm_event_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [7:0]  reg_addr_i = '0;
    logic [7:0]  reg_wdata_i = '0;
    logic        reg_we_i = 1'b0;
    logic [7:0]  reg_rdata_o;
    logic [2:0]  event_o;
    logic        alarm_irq_o;
    logic [31:0] count_o;

    always #2.5 clk = ~clk;

    alarm_event_unit i_alarm_event_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_we_i    (reg_we_i),
        .reg_rdata_o (reg_rdata_o),
        .event_o     (event_o),
        .alarm_irq_o (alarm_irq_o),
        .count_o     (count_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // reference model state
    logic [31:0] m_cnt;
    logic [31:0] m_match [3];
    logic [2:0]  m_flag, m_en;
    logic        m_ar;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(logic [7:0] a);
        if (a == 8'h07) return {1'b0, m_flag, m_ar, m_en};
        if (a <= 8'h03) return m_cnt[8*a +: 8];
        if (a >= 8'h10 && a <= 8'h1B) return m_match[(a - 8'h10) / 4][8*((a - 8'h10) % 4) +: 8];
        return 8'h00;
    endfunction

    function automatic logic [2:0] model_event(logic tk);
        logic [2:0] ev = '0;
        for (int i = 0; i < 3; i++) begin
            ev[i] = m_en[i] && tk && ((m_cnt + 32'd1) == m_match[i]);
        end
        return ev;
    endfunction

    // one clock cycle: drive, check current state, advance model
    task automatic cycle(logic tk, logic we, logic [7:0] a, logic [7:0] wd, string tag);
        logic [2:0] ev;
        @(negedge clk);
        tick_i = tk; reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
        #1;
        ev = model_event(tk);
        chk("R6 event", {29'd0, event_o}, {29'd0, ev});
        chk("R7 count", count_o, m_cnt);
        chk("R8 irq", {31'd0, alarm_irq_o}, {31'd0, (m_flag != 3'b000)});
        chk(tag, {24'd0, reg_rdata_o}, {24'd0, model_read(a)});
        if (tk) m_cnt = (m_ar && ev[0]) ? 32'd0 : m_cnt + 32'd1;
        if (we) begin
            if (a == 8'h07) begin
                m_en = wd[2:0]; m_ar = wd[3]; m_flag = m_flag & wd[6:4];
            end else if (a >= 8'h10 && a <= 8'h1B) begin
                m_match[(a - 8'h10) / 4][8*((a - 8'h10) % 4) +: 8] = wd;
            end
        end
        m_flag = m_flag | ev;
    endtask

    function automatic string tag_for(logic [7:0] a);
        if (a == 8'h07) return "R1 cfg read";
        if (a <= 8'h03) return "R7 count read";
        return "R11 match read";
    endfunction

    initial begin
        #(200000 * 5ns);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        m_cnt = '0; m_flag = '0; m_en = '0; m_ar = 1'b0;
        for (int i = 0; i < 3; i++) m_match[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: reset state
        cycle(0, 0, 8'h07, 8'h00, "R10 cfg after reset");
        cycle(0, 0, 8'h00, 8'h00, "R10 count after reset");
        cycle(0, 0, 8'h15, 8'h00, "R10 match after reset");
        // R11: match byte write/readback, unmapped read
        cycle(0, 1, 8'h10, 8'h05, "R11 match write");
        cycle(0, 0, 8'h10, 8'h00, "R11 match readback");
        cycle(0, 0, 8'h2A, 8'h00, "R11 unmapped reads 0");
        // R1: reserved bit ignores writes
        cycle(0, 1, 8'h07, 8'h81, "R1 cfg write");
        cycle(0, 0, 8'h07, 8'h00, "R1 reserved bit");
        // R2/R6: alarm 0 fires on the fifth tick
        for (int k = 0; k < 5; k++) cycle(1, 0, 8'h07, 8'h00, "R2 flag set");
        cycle(0, 0, 8'h07, 8'h00, "R2 flag visible");
        // R3: writing 1 keeps, writing 0 clears
        cycle(0, 1, 8'h07, 8'hF1, "R3 write ones");
        cycle(0, 0, 8'h07, 8'h00, "R3 flag kept");
        cycle(0, 1, 8'h07, 8'h01, "R3 write zero");
        cycle(0, 0, 8'h07, 8'h00, "R3 flag cleared");
        // R5: alarm 1 matches but is disabled
        cycle(0, 1, 8'h14, 8'h06, "R5 match1 write");
        cycle(1, 0, 8'h07, 8'h00, "R5 disabled alarm");
        cycle(0, 0, 8'h07, 8'h00, "R5 flag stays clear");
        // R4: auto-reset on alarm 0 at count 8
        cycle(0, 1, 8'h10, 8'h08, "R4 match0 write");
        cycle(0, 1, 8'h07, 8'h09, "R4 enable autorst");
        cycle(1, 0, 8'h07, 8'h00, "R4 tick");
        cycle(1, 0, 8'h07, 8'h00, "R4 auto-reset tick");
        cycle(0, 0, 8'h00, 8'h00, "R4 count zero");
        // R9: set beats same-cycle clear
        cycle(0, 1, 8'h10, 8'h01, "R9 match0 write");
        cycle(1, 1, 8'h07, 8'h09, "R9 collide");
        cycle(0, 0, 8'h07, 8'h00, "R9 flag survives");

        // constrained random phase
        for (int n = 0; n < 6000; n++) begin
            logic [7:0] a;
            logic [7:0] wd;
            logic       we;
            int         sel = $urandom % 18;
            if (sel == 0)       a = 8'h07;
            else if (sel < 5)   a = 8'(sel - 1);
            else if (sel < 17)  a = 8'(8'h10 + sel - 5);
            else                a = 8'h30;
            we = ($urandom % 5) == 0;
            if (a >= 8'h10 && a <= 8'h1B && ($urandom % 5) != 0) begin
                logic [31:0] near = m_cnt + 32'($urandom % 8);
                wd = near[8*((a - 8'h10) % 4) +: 8];
            end else if (a == 8'h07) begin
                wd = 8'($urandom) | 8'h07;
            end else begin
                wd = 8'($urandom);
            end
            cycle(($urandom % 2) == 1, we, a, wd, tag_for(a));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule